// File: doc/BRIEF.md
# Sub-harmonic quadrature DAC up-converter

The block turns a commanded in-phase/quadrature drive pair into a single stream of DAC words. It does not synthesise the carrier at the DAC fundamental. The DAC runs at a quadrature sub-harmonic of the wanted frequency, fs = 4·f/(2n+1). Each update the block emits the next of four rotated quadrature components. The analog output then carries lines at fs/4 and at further spacings of fs/4·(2n+1). An external band-pass filter picks the image that sits on the cavity frequency. For example, a 40 MHz update rate gives lines at 10, 30, 50 and 70 MHz, and the 50 MHz line is kept.

A clock-enable divider on the master reference clock sets the update rate. A 276 MHz reference divided by 1, 2, 3 or 6 gives 276, 138, 92 or 46 MHz. These serve 345, 172.5, 115 and 57.5 MHz cavities. One input selects which of the two rotation directions is used, according to 2n+1 modulo 4. New set-points are buffered and take effect only on the first sample of a rotation. The output register changes only on an update.

Top module: `quad_upconv`

## Requirements
- R1: While rst_ni is low, and until the first update after it rises, dac_o holds the code for zero, which is mid-scale (only the MSB set). The rotation phase, the divider count and all set-points also start at zero.
- R2: upd_o is high for one clock in every N master clocks. N is 1, 2, 3 or 6 for div_sel_i = 0, 1, 2 or 3.
- R3: dac_o changes only on the rising edge at which upd_o is high.
- R4: With parity_i = 0, the rotation is complete after four consecutive updates. Its values are +I, +Q, −I, −Q, for the 2n+1 ≡ 1 mod 4 case.
- R5: With parity_i = 1, the four updates are +I, −Q, −I, +Q, for the 2n+1 ≡ 3 mod 4 case.
- R6: A pulse on load_i captures i_set_i and q_set_i into a pending pair. That pair is first used at the next first-of-four update. Samples later in a rotation always use the pair that began it.
- R7: parity_i is sampled only at the first update of a rotation and holds for the other three.
- R8: Negation saturates. The negative of the most negative value is output as the most positive value.
- R9: dac_o is offset binary: the two's-complement sample with its MSB inverted.
- R10: The first update after reset is the first (+I) sample of a rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_sel_i | input | 2 | Update-rate divider code (0..3 → divide by 1, 2, 3, 6) |
| parity_i | input | 1 | Rotation direction: 0 for 2n+1 ≡ 1 mod 4, 1 for 2n+1 ≡ 3 mod 4 |
| load_i | input | 1 | Set-point capture strobe |
| i_set_i | input | DW | In-phase set-point, two's complement |
| q_set_i | input | DW | Quadrature set-point, two's complement |
| upd_o | output | 1 | DAC update enable; dac_o changes at the edge where it is high |
| dac_o | output | DW | Offset-binary DAC word |

## Verification
The bench builds the block with DW = 8. At that width the most negative value, −128, is easy to reach, so the saturating negation is exercised at its corner many times in each sweep. The sweep covers all four divider codes and both parities. It loads set-points, including both full-scale extremes, at every position within a rotation, and toggles parity in the middle of rotations. The expected word is compared on every clock, so holding between updates and hand-over at the start of a rotation are checked at every divide ratio.

// File: rtl/qup_pkg.sv
package qup_pkg;
  typedef enum logic [1:0] {PH_0, PH_1, PH_2, PH_3} phase_e;

  localparam int unsigned MAX_RATIO = 6;

  function automatic int unsigned div_ratio(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 3;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/qup_clk_en.sv
module qup_clk_en
  import qup_pkg::*;
#(
  parameter int unsigned CW = $clog2(MAX_RATIO)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  output logic       en_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  always_comb lim = CW'(div_ratio(sel_i) - 1);
  assign en_o = (cnt_q == lim);

  // a ratio change mid-count folds an out-of-range count back to zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q >= lim)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX_RATIO - 1));

  p_div_unit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 2'd0 && $past(sel_i) == 2'd0) |-> en_o);

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && sel_i != 2'd0 && $stable(sel_i)) |=> !en_o);
endmodule

// File: rtl/qup_rot.sv
module qup_rot
  import qup_pkg::*;
#(
  parameter int unsigned DW = 14
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 load_i,
  input  logic                 parity_i,
  input  logic signed [DW-1:0] i_set_i,
  input  logic signed [DW-1:0] q_set_i,
  output logic signed [DW-1:0] mag_o,
  output logic                 neg_o,
  output logic                 first_o
);
  phase_e                ph_q;
  logic signed [DW-1:0]  pend_i_q, pend_q_q;
  logic signed [DW-1:0]  act_i_q, act_q_q;
  logic                  par_q;
  logic signed [DW-1:0]  cur_i, cur_q;
  logic                  cur_par;

  // at phase 0 the pending pair and live parity are used directly
  always_comb begin
    cur_i   = (ph_q == PH_0) ? pend_i_q : act_i_q;
    cur_q   = (ph_q == PH_0) ? pend_q_q : act_q_q;
    cur_par = (ph_q == PH_0) ? parity_i : par_q;
    unique case (ph_q)
      PH_0: begin mag_o = cur_i; neg_o = 1'b0;     end
      PH_1: begin mag_o = cur_q; neg_o = cur_par;  end
      PH_2: begin mag_o = cur_i; neg_o = 1'b1;     end
      PH_3: begin mag_o = cur_q; neg_o = ~cur_par; end
    endcase
  end

  assign first_o = (ph_q == PH_0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_i_q <= '0;
      pend_q_q <= '0;
    end else if (load_i) begin
      pend_i_q <= i_set_i;
      pend_q_q <= q_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_0;
      act_i_q <= '0;
      act_q_q <= '0;
      par_q   <= 1'b0;
    end else if (en_i) begin
      ph_q <= phase_e'(ph_q + 2'd1);
      if (ph_q == PH_0) begin
        act_i_q <= pend_i_q;
        act_q_q <= pend_q_q;
        par_q   <= parity_i;
      end
    end
  end

  p_act_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && ph_q == PH_0) |=> ($stable(act_i_q) && $stable(act_q_q)));

  p_par_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && ph_q == PH_0) |=> $stable(par_q));

  p_ph_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ph_q == phase_e'($past(ph_q) + 2'd1));

  p_ph_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ph_q));
endmodule

// File: rtl/qup_fmt.sv
module qup_fmt #(
  parameter int unsigned DW         = 14,
  parameter bit          OFFSET_BIN = 1'b1
) (
  input  logic signed [DW-1:0] mag_i,
  input  logic                 neg_i,
  output logic        [DW-1:0] code_o
);
  localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAX_V = {1'b0, {(DW-1){1'b1}}};

  logic signed [DW-1:0] val;

  always_comb begin
    if (!neg_i)              val = mag_i;
    else if (mag_i == MIN_V) val = MAX_V;
    else                     val = -mag_i;
  end

  generate
    if (OFFSET_BIN) begin : g_offset
      assign code_o = {~val[DW-1], val[DW-2:0]};
    end else begin : g_twos
      assign code_o = val;
    end
  endgenerate
endmodule

// File: rtl/quad_upconv.sv
module quad_upconv
  import qup_pkg::*;
#(
  parameter int unsigned DW         = 14,
  parameter bit          OFFSET_BIN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    div_sel_i,
  input  logic          parity_i,
  input  logic          load_i,
  input  logic [DW-1:0] i_set_i,
  input  logic [DW-1:0] q_set_i,
  output logic          upd_o,
  output logic [DW-1:0] dac_o
);
  localparam logic [DW-1:0] ZERO_CODE = OFFSET_BIN ? {1'b1, {(DW-1){1'b0}}} : '0;
  localparam logic [DW-1:0] SAT_CODE  = OFFSET_BIN ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MIN_V = {1'b1, {(DW-1){1'b0}}};

  logic                 en;
  logic signed [DW-1:0] mag;
  logic                 neg;
  logic                 first;
  logic [DW-1:0]        code;
  logic [DW-1:0]        dac_q;

  qup_clk_en u_clk_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (div_sel_i),
    .en_o  (en)
  );

  qup_rot #(.DW(DW)) u_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .load_i  (load_i),
    .parity_i(parity_i),
    .i_set_i (i_set_i),
    .q_set_i (q_set_i),
    .mag_o   (mag),
    .neg_o   (neg),
    .first_o (first)
  );

  qup_fmt #(.DW(DW), .OFFSET_BIN(OFFSET_BIN)) u_fmt (
    .mag_i (mag),
    .neg_i (neg),
    .code_o(code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  dac_q <= ZERO_CODE;
    else if (en)  dac_q <= code;
  end

  assign upd_o = en;
  assign dac_o = dac_q;

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> $stable(dac_q));

  p_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && neg && mag == MIN_V) |=> dac_q == SAT_CODE);

  p_first_plain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && first) |-> !neg);
endmodule

// File: tb/quad_upconv_test.sv
module quad_upconv_test;
  localparam int DW  = 8;
  localparam int MID = 1 << (DW - 1);
  localparam int MSK = (1 << DW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           div_sel = 2'd0;
  logic                 parity = 1'b0;
  logic                 load = 1'b0;
  logic signed [DW-1:0] i_set = '0;
  logic signed [DW-1:0] q_set = '0;
  logic                 upd;
  logic [DW-1:0]        dac;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  quad_upconv #(.DW(DW)) uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .div_sel_i(div_sel),
    .parity_i (parity),
    .load_i   (load),
    .i_set_i  (i_set),
    .q_set_i  (q_set),
    .upd_o    (upd),
    .dac_o    (dac)
  );

  function automatic int neg_sat(input int v);
    return (v == -MID) ? MID - 1 : -v;
  endfunction

  function automatic int to_code(input int v);
    return (v & MSK) ^ MID;
  endfunction

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 3;
      default: return 6;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated away from the active edge
  int    k = 0;
  int    pend_i = 0, pend_q = 0, act_i = 0, act_q = 0;
  bit    par_a = 1'b0;
  int    exp_code = MID;
  string tag = "R1";
  int    gap = 0, age = 0;
  logic [1:0] prev_sel = 2'd0;

  always @(negedge clk) begin
    if (!rst_n) begin
      k = 0; pend_i = 0; pend_q = 0; act_i = 0; act_q = 0; par_a = 1'b0;
      exp_code = MID; tag = "R3"; gap = 0; age = 0; prev_sel = div_sel;
      check("R1", int'(dac), MID);
    end else begin
      check(tag, int'(dac), exp_code);
      if (div_sel != prev_sel) age = 0;
      prev_sel = div_sel;
      gap++;
      if (upd) begin
        int ph, v;
        bit sat;
        age++;
        if (age >= 2) check("R2", gap, ratio(div_sel));
        gap = 0;
        ph = k % 4;
        if (ph == 0) begin
          act_i = pend_i; act_q = pend_q; par_a = parity;
        end
        sat = 1'b0;
        case (ph)
          0: v = act_i;
          1: begin v = par_a ? neg_sat(act_q) : act_q; sat = par_a && act_q == -MID; end
          2: begin v = neg_sat(act_i); sat = act_i == -MID; end
          default: begin v = par_a ? act_q : neg_sat(act_q); sat = !par_a && act_q == -MID; end
        endcase
        exp_code = to_code(v);
        if (k < 4)                                          tag = "R10";
        else if (sat)                                       tag = "R8";
        else if (ph == 0)                                   tag = "R9";
        else if (pend_i != act_i || pend_q != act_q)        tag = "R6";
        else if (parity != par_a)                           tag = "R7";
        else                                                tag = par_a ? "R5" : "R4";
        k++;
      end else begin
        tag = "R3";
      end
      if (load) begin
        pend_i = int'(i_set);
        pend_q = int'(q_set);
      end
    end
  end

  task automatic tick(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_load(input int iv, input int qv);
    i_set = DW'(iv);
    q_set = DW'(qv);
    load  = 1'b1;
    tick(1);
    load  = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
  endtask

  initial begin
    tick(2);
    do_reset();
    for (int d = 0; d < 4; d++) begin
      int r;
      r = ratio(2'(d));
      div_sel = 2'(d);
      parity  = 1'b0;
      do_reset();
      tick(8 * r);
      do_load(37, -90);                    // R4 pattern with distinct I/Q
      tick(12 * r);
      do_load(-128, 127);                  // R8 at −I
      tick(12 * r);
      parity = 1'b1;                       // R5
      do_load(127, -128);                  // R8 at −Q
      tick(12 * r);
      for (int j = 0; j < 16; j++) begin   // R6/R7: loads and parity flips at every phase
        do_load((j * 29) % 256 - 128, 100 - j * 13);
        if (j % 3 == 0) parity = ~parity;
        tick(j % 5 + r);
      end
      tick(12 * r);
    end
    // ratio change without reset, then steady
    for (int d = 3; d >= 0; d--) begin
      div_sel = 2'(d);
      do_load(-5 * d - 1, 7 * d + 3);
      tick(20 * ratio(2'(d)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule